// File: doc/BRIEF.md
# Light-Load Operating Mode Controller

This block decides, for one synchronous buck phase, whether the phase runs in fixed-frequency PWM or in hysteretic pulse-skipping operation. Each rising edge of `clk` is one switching period. In that period, an external sampler may present the polarity of the phase node, taken at the end of low-side conduction. The block counts runs of same-polarity samples. A run of `RUN_LEN` samples (eight by default) that point away from the present mode flips the mode. A single contrary sample resets the run, so the mode does not dither near the load boundary.

In PWM mode the block passes the high-side request of the external modulator through to the gate requests, and drives the low side as its complement. In hysteretic mode the low side stays off (diode emulation). The high side is turned on when the output comparator reports the lower limit and turned off when it reports the upper limit. Every gate request is registered on `clk`, so hysteretic pulses stay aligned to the switching clock and keep their phase offset to a neighbouring phase. A separate step-load flag takes the block out of hysteretic mode on the next edge.

Top module: `lmc_top`

## Requirements
- R1: In PWM mode (`hyst_mode`=0), after each edge `hs_req` equals the `pwm_hs` value sampled at that edge and `ls_req` is its complement.
- R2: In PWM mode, `RUN_LEN` consecutive valid samples with `phase_pos`=1 (1 = phase node positive, current reversing) set `hyst_mode` to 1 at the edge that takes the last sample.
- R3: In hysteretic mode, `RUN_LEN` consecutive valid samples with `phase_pos`=0 (current continuous) return `hyst_mode` to 0 at the edge that takes the last sample.
- R4: A valid sample of the polarity that keeps the present mode clears the run. A cycle with `phase_vld`=0 neither counts nor clears. Each mode change also clears the run.
- R5: At the edge that enters hysteretic mode, both `hs_req` and `ls_req` go to 0.
- R6: In hysteretic mode, after the entry edge, `hs_req` is set at the edge that sees `out_below`=1, cleared at the edge that sees `out_above`=1 (clearing wins when both are 1), and held otherwise.
- R7: In hysteretic mode `ls_req` stays 0, and `diode_emu` is 1 exactly when `hyst_mode`=1 and `hs_req`=0.
- R8: `load_step`=1 in hysteretic mode returns the block to PWM mode at the next edge, with gate requests as in R1 and the run cleared.
- R9: After reset, and at each edge where `en`=0, the block is in PWM mode with the run at zero and `hs_req`, `ls_req` and `diode_emu` all 0.
- R10: `hs_req` and `ls_req` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock, one edge per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Phase enable; 0 holds the block idle in PWM mode |
| phase_vld | input | 1 | A polarity sample is present this period |
| phase_pos | input | 1 | Sampled polarity: 1 positive, 0 negative |
| out_below | input | 1 | Output at or under the hysteretic lower limit |
| out_above | input | 1 | Output at or over the hysteretic upper limit |
| load_step | input | 1 | Output dropped under the hysteretic regulation level |
| pwm_hs | input | 1 | High-side request from the PWM modulator |
| hyst_mode | output | 1 | 1 = hysteretic mode, 0 = PWM mode |
| hs_req | output | 1 | High-side gate enable request |
| ls_req | output | 1 | Low-side gate enable request |
| diode_emu | output | 1 | Both switches held off in hysteretic mode |

## Verification
The bench builds the block with the default run length of eight and with the clear-priority variant of the hysteretic pulse latch. That run length makes the run that stops one short of the limit reachable in a few cycles: seven matching samples, a contrary sample, and then a full run of eight. The same holds for gaps in `phase_vld` placed inside a run. The clear-priority variant sets what happens when both output comparator flags are raised in the same period, and the bench drives that case.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
   typedef enum logic {
      MODE_PWM  = 1'b0,
      MODE_HYST = 1'b1
   } lmc_mode_e;

   typedef struct packed {
      logic hs;
      logic ls;
   } lmc_gate_t;
endpackage

// File: rtl/lmc_run_counter.sv
module lmc_run_counter #(
   parameter int RUN_LEN = 8,
   localparam int CW     = $clog2(RUN_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic smp_vld,
   input  logic smp_match,
   output logic run_done
);
   localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (smp_vld)
         cnt_q <= smp_match ? cnt_q + CW'(1) : '0;
   end

   assign run_done = smp_vld && smp_match && (cnt_q == LAST);
endmodule

// File: rtl/lmc_mode_fsm.sv
module lmc_mode_fsm
   import lmc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      run_done,
   input  logic      load_step,
   output lmc_mode_e mode_q,
   output lmc_mode_e mode_d,
   output logic      mode_chg,
   output logic      enter_hyst
);
   always_comb begin
      if (!en)
         mode_d = MODE_PWM;
      else if (mode_q == MODE_HYST && load_step)
         mode_d = MODE_PWM;
      else if (run_done)
         mode_d = (mode_q == MODE_PWM) ? MODE_HYST : MODE_PWM;
      else
         mode_d = mode_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_PWM;
      else        mode_q <= mode_d;
   end

   assign mode_chg   = (mode_d != mode_q);
   assign enter_hyst = (mode_q == MODE_PWM) && (mode_d == MODE_HYST);
endmodule

// File: rtl/lmc_gate_seq.sv
module lmc_gate_seq
   import lmc_pkg::*;
#(
   parameter bit ABOVE_WINS = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  lmc_mode_e mode_d,
   input  logic      enter_hyst,
   input  logic      pwm_hs,
   input  logic      out_below,
   input  logic      out_above,
   output lmc_gate_t gate_q,
   output logic      demu_q
);
   logic      pulse_q;
   logic      pulse_nxt;
   logic      pulse_d;
   lmc_gate_t gate_d;

   generate
      if (ABOVE_WINS) begin : g_clr_prio
         assign pulse_nxt = out_above ? 1'b0 : (out_below ? 1'b1 : pulse_q);
      end else begin : g_set_prio
         assign pulse_nxt = out_below ? 1'b1 : (out_above ? 1'b0 : pulse_q);
      end
   endgenerate

   always_comb begin
      gate_d  = '0;
      pulse_d = 1'b0;
      if (!en) begin
         gate_d = '0;
      end else if (mode_d == MODE_PWM) begin
         gate_d.hs = pwm_hs;
         gate_d.ls = !pwm_hs;
      end else if (enter_hyst) begin
         gate_d = '0;
      end else begin
         pulse_d   = pulse_nxt;
         gate_d.hs = pulse_nxt;
         gate_d.ls = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q  <= '0;
         pulse_q <= 1'b0;
         demu_q  <= 1'b0;
      end else begin
         gate_q  <= gate_d;
         pulse_q <= pulse_d;
         demu_q  <= en && (mode_d == MODE_HYST) && !gate_d.hs;
      end
   end
endmodule

// File: rtl/lmc_top.sv
module lmc_top
   import lmc_pkg::*;
#(
   parameter int RUN_LEN    = 8,
   parameter bit ABOVE_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic phase_vld,
   input  logic phase_pos,
   input  logic out_below,
   input  logic out_above,
   input  logic load_step,
   input  logic pwm_hs,
   output logic hyst_mode,
   output logic hs_req,
   output logic ls_req,
   output logic diode_emu
);
   generate
      if (RUN_LEN < 2) begin : g_bad_run_len
         $error("lmc_top: RUN_LEN must be at least 2");
      end
   endgenerate

   lmc_mode_e mode_q;
   lmc_mode_e mode_d;
   logic      mode_chg;
   logic      enter_hyst;
   logic      run_done;
   logic      smp_match;
   lmc_gate_t gate_q;

   assign smp_match = (mode_q == MODE_PWM) ? phase_pos : !phase_pos;

   lmc_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!en || mode_chg),
      .smp_vld   (phase_vld),
      .smp_match (smp_match),
      .run_done  (run_done)
   );

   lmc_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .run_done   (run_done),
      .load_step  (load_step),
      .mode_q     (mode_q),
      .mode_d     (mode_d),
      .mode_chg   (mode_chg),
      .enter_hyst (enter_hyst)
   );

   lmc_gate_seq #(.ABOVE_WINS(ABOVE_WINS)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .mode_d     (mode_d),
      .enter_hyst (enter_hyst),
      .pwm_hs     (pwm_hs),
      .out_below  (out_below),
      .out_above  (out_above),
      .gate_q     (gate_q),
      .demu_q     (diode_emu)
   );

   assign hyst_mode = (mode_q == MODE_HYST);
   assign hs_req    = gate_q.hs;
   assign ls_req    = gate_q.ls;
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic phase_vld,
   input logic phase_pos,
   input logic load_step,
   input logic hyst_mode,
   input logic hs_req,
   input logic ls_req,
   input logic diode_emu
);
   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_req && ls_req));

   assert_entry_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hyst_mode) |-> (!hs_req && !ls_req));

   assert_entry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hyst_mode) |-> $past(en && phase_vld && phase_pos));

   assert_exit_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hyst_mode) |-> $past(!en || load_step || (phase_vld && !phase_pos)));

   assert_no_lowside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hyst_mode |-> !ls_req);

   assert_demu_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      diode_emu |-> (hyst_mode && !hs_req && !ls_req));

   assert_step_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hyst_mode && load_step) |=> !hyst_mode);

   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!hyst_mode && !hs_req && !ls_req && !diode_emu));
endmodule

bind lmc_top lmc_checker u_lmc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .phase_vld (phase_vld),
   .phase_pos (phase_pos),
   .load_step (load_step),
   .hyst_mode (hyst_mode),
   .hs_req    (hs_req),
   .ls_req    (ls_req),
   .diode_emu (diode_emu)
);

// File: tb/lmc_top_tb.sv
`timescale 1ns/1ps
module lmc_top_tb;
   typedef struct {
      logic  mode;
      logic  hs;
      logic  ls;
      logic  demu;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, phase_vld = 1'b0, phase_pos = 1'b0;
   logic out_below = 1'b0, out_above = 1'b0, load_step = 1'b0, pwm_hs = 1'b0;
   logic hyst_mode, hs_req, ls_req, diode_emu;

   int checks = 0;
   int failures = 0;
   exp_t sb[$];
   string cur_tag = "R9";

   // reference state, derived from the requirements
   logic m_mode = 1'b0;
   int   m_cnt = 0;
   logic m_pulse = 1'b0;

   always #2.5 clk = ~clk;

   lmc_top u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .phase_vld(phase_vld),
      .phase_pos(phase_pos), .out_below(out_below), .out_above(out_above),
      .load_step(load_step), .pwm_hs(pwm_hs), .hyst_mode(hyst_mode),
      .hs_req(hs_req), .ls_req(ls_req), .diode_emu(diode_emu)
   );

   task automatic cyc(input logic e, input logic v, input logic p,
                      input logic lo, input logic hi, input logic st,
                      input logic ph);
      exp_t x;
      logic nmode;
      @(negedge clk);
      en = e; phase_vld = v; phase_pos = p; out_below = lo;
      out_above = hi; load_step = st; pwm_hs = ph;
      x.tag = cur_tag;
      if (!e) begin
         m_mode = 1'b0; m_cnt = 0; m_pulse = 1'b0;
         x.mode = 1'b0; x.hs = 1'b0; x.ls = 1'b0; x.demu = 1'b0;
      end else begin
         nmode = m_mode;
         if (m_mode && st) begin
            nmode = 1'b0; m_cnt = 0;
         end else if (v) begin
            if (p == !m_mode) begin
               if (m_cnt + 1 == 8) begin nmode = !m_mode; m_cnt = 0; end
               else m_cnt = m_cnt + 1;
            end else m_cnt = 0;
         end
         if (!nmode) begin
            x.hs = ph; x.ls = !ph; m_pulse = 1'b0;
         end else if (!m_mode) begin
            x.hs = 1'b0; x.ls = 1'b0; m_pulse = 1'b0;
         end else begin
            m_pulse = hi ? 1'b0 : (lo ? 1'b1 : m_pulse);
            x.hs = m_pulse; x.ls = 1'b0;
         end
         m_mode = nmode;
         x.mode = nmode;
         x.demu = nmode && !x.hs;
      end
      sb.push_back(x);
   endtask

   // monitor: compares just after each edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t x;
         x = sb.pop_front();
         checks++;
         if (hyst_mode !== x.mode || hs_req !== x.hs || ls_req !== x.ls ||
             diode_emu !== x.demu) begin
            failures++;
            $display("FAIL %s: got mode=%b hs=%b ls=%b demu=%b exp mode=%b hs=%b ls=%b demu=%b",
                     x.tag, hyst_mode, hs_req, ls_req, diode_emu,
                     x.mode, x.hs, x.ls, x.demu);
         end
      end
   end

   initial begin
      #100000;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;   // R9 reset state
      if (hyst_mode !== 1'b0 || hs_req !== 1'b0 || ls_req !== 1'b0 || diode_emu !== 1'b0) begin
         failures++;
         $display("FAIL R9: got mode=%b hs=%b ls=%b demu=%b exp all 0",
                  hyst_mode, hs_req, ls_req, diode_emu);
      end
      @(negedge clk); rst_n = 1'b1;

      cur_tag = "R1";  // PWM pass-through
      for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, i[0]);

      cur_tag = "R4";  // seven highs, one low, gaps do not clear
      for (int i = 0; i < 7; i++) cyc(1, 1, 1, 0, 0, 0, 1);
      cyc(1, 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, 0, 0, 1);

      cur_tag = "R2";  // eighth high sample of the run enters hysteretic
      cyc(1, 1, 1, 1, 0, 0, 1);
      cur_tag = "R5";
      if (m_mode !== 1'b1) $display("bench model did not enter hysteretic mode");

      cur_tag = "R6";  // pulse on lower limit, off at upper limit
      cyc(1, 1, 1, 0, 0, 0, 1);
      cyc(1, 1, 1, 1, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 1, 0, 0);
      cyc(1, 0, 0, 1, 1, 0, 0);
      cur_tag = "R7";
      cyc(1, 1, 1, 0, 0, 0, 1);
      cyc(1, 0, 0, 1, 0, 0, 1);

      cur_tag = "R3";  // seven lows, one high, then eight lows
      for (int i = 0; i < 7; i++) cyc(1, 1, 0, 0, 0, 0, 1);
      cyc(1, 1, 1, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0, 0, i[0]);
      cyc(1, 0, 0, 0, 0, 0, 1);

      cur_tag = "R8";  // re-enter, then a step load
      for (int i = 0; i < 8; i++) cyc(1, 1, 1, 0, 0, 0, 0);
      cyc(1, 0, 0, 1, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 1, 1);
      cyc(1, 0, 0, 0, 0, 0, 0);

      cur_tag = "R9";  // disable clears the run
      for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 0, 0, 1);
      cyc(0, 1, 1, 0, 0, 0, 1);
      for (int i = 0; i < 7; i++) cyc(1, 1, 1, 0, 0, 0, 0);
      cur_tag = "R10";
      cyc(1, 1, 1, 0, 0, 0, 1);
      cyc(1, 0, 0, 1, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 1);

      @(negedge clk);
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule